// File: doc/BRIEF.md
# YUV to RGB Color Space Converter

This block turns a stream of 8-bit luma/chroma pixels into 8-bit red, green and blue components. It uses a programmable 3x4 matrix. Each output component is a weighted sum of the three input components plus a constant. The weights are signed fixed-point values with 10 fractional bits. The constant is a signed fixed-point value with 4 fractional bits. Each result is rounded to the nearest integer and saturated to 0..255. A bypass mode passes RGB input through untouched.

Software writes the matrix and the bypass flag into a shadow register set at any time. The shadow set is copied into the working set only on a one-cycle frame-start pulse, so the coefficients never change in the middle of a frame. Pixels enter with a single-cycle valid strobe and leave three clock cycles later with a matching valid strobe.

Top module: `yuv2rgb_csc`

## Requirements
- R1: After reset the working and shadow sets hold the limited-range to full-range BT.601 matrix, given per output below. Bypass is off.
  - R: Y 0x4a7, U 0, V 0x662, constant 0x3211.
  - G: Y 0x4a7, U 0x1e6f, V 0x1cbf, constant 0x877.
  - B: Y 0x4a7, U 0x812, V 0, constant 0x2eb1.
- R2: A weight is bits 12:0 of its register, read as signed two's complement with 10 fractional bits. Bits 31:13 are ignored.
- R3: A constant is bits 13:0 of its register, read as signed two's complement with 4 fractional bits. Bits 31:14 are ignored. The constant is scaled by 64 to line up with the product sums.
- R4: Configuration addresses 0..3 hold the G row, 4..7 the R row and 8..11 the B row. Within a row the order is Y weight, U weight, V weight, constant. Address 12 bit 0 is the bypass flag. Addresses 13..15 are ignored.
- R5: The sum is rounded to the nearest integer, with exact halves rounded up: (sum + 512) shifted right arithmetically by 10.
- R6: A rounded result below 0 gives 0, and one above 255 gives 255.
- R7: out_valid follows in_valid exactly three cycles later. Each output belongs to the pixel accepted three cycles before.
- R8: With bypass in effect, out_r = in_c0, out_g = in_c1 and out_b = in_c2.
- R9: Configuration writes do not affect conversion until a frame_start pulse. A pixel accepted in the same cycle as frame_start is converted with the newly committed set.
- R10: A write in the same cycle as frame_start lands in the shadow set but is not committed by that pulse.
- R11: During and right after reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| frame_start | input | 1 | Commits the shadow set to the working set |
| in_valid | input | 1 | Input pixel strobe |
| in_c0 | input | 8 | Y, or R in bypass |
| in_c1 | input | 8 | U, or G in bypass |
| in_c2 | input | 8 | V, or B in bypass |
| out_valid | output | 1 | Output pixel strobe |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
A frame-start commit can fall in the same cycle as an accepted pixel, and also in the same cycle as a configuration write. The bench drives both collisions on purpose. A pixel issued together with the pulse must show the new matrix or the new bypass state. A write issued together with the pulse must stay invisible until the following pulse. The scoreboard's reference copy applies the commit before the write within each cycle, so any disagreement in ordering shows up as a component mismatch.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int NUM_ROWS = 3;
  localparam int TERMS    = 4;
  localparam int NUM_REGS = NUM_ROWS * TERMS;
  localparam int REG_W    = 32;

  // Power-on matrix, index = row*4 + term, rows G, R, B; terms Y, U, V, constant
  function automatic logic [REG_W-1:0] default_coef(input int idx);
    logic [REG_W-1:0] v;
    case (idx)
      0, 4, 8: v = 32'h0000_04a7;
      1:       v = 32'h0000_1e6f;
      2:       v = 32'h0000_1cbf;
      3:       v = 32'h0000_0877;
      6:       v = 32'h0000_0662;
      7:       v = 32'h0000_3211;
      9:       v = 32'h0000_0812;
      11:      v = 32'h0000_2eb1;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/csc_regfile.sv
module csc_regfile
  import csc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_we,
  input  logic [ADDR_W-1:0]                cfg_addr,
  input  logic [REG_W-1:0]                 cfg_wdata,
  input  logic                             frame_start,
  output logic [NUM_REGS-1:0][REG_W-1:0]   eff_coef,
  output logic                             eff_bypass
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_REGS);

  logic [NUM_REGS-1:0][REG_W-1:0] shadow_q, active_q;
  logic                           shadow_byp_q, active_byp_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q[i] <= default_coef(i);
        active_q[i] <= default_coef(i);
      end else begin
        if (frame_start) active_q[i] <= shadow_q[i];
        if (cfg_we && cfg_addr == ADDR_W'(i)) shadow_q[i] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_byp_q <= 1'b0;
      active_byp_q <= 1'b0;
    end else begin
      if (frame_start) active_byp_q <= shadow_byp_q;
      if (cfg_we && cfg_addr == CTRL_ADDR) shadow_byp_q <= cfg_wdata[0];
    end
  end

  // Pixel in the commit cycle already sees the shadow set
  always_comb begin
    eff_coef   = frame_start ? shadow_q : active_q;
    eff_bypass = frame_start ? shadow_byp_q : active_byp_q;
  end

  assert_hold_between_frames_R9: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(active_q) && $stable(active_byp_q)));

  assert_commit_old_value_R10: assert property (@(posedge clk) disable iff (rst)
    (frame_start && cfg_we && cfg_addr < CTRL_ADDR)
      |=> active_q[$past(cfg_addr)] == $past(shadow_q[cfg_addr]));

  assert_shadow_write_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr < CTRL_ADDR) |=> shadow_q[$past(cfg_addr)] == $past(cfg_wdata));
endmodule

// File: rtl/csc_mac.sv
module csc_mac #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 13,
  parameter int OFF_W  = 14,
  parameter int ALIGN  = 6,
  parameter int ACC_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2:0][PIX_W-1:0]    pix,
  input  logic [2:0][COEF_W-1:0]   coef,
  input  logic [OFF_W-1:0]         offset,
  output logic signed [ACC_W-1:0]  acc
);
  localparam int PROD_W = COEF_W + PIX_W + 1;
  localparam int EXT_W  = ACC_W - OFF_W - ALIGN;

  logic signed [PROD_W-1:0] prod_q [3];
  logic signed [ACC_W-1:0]  off_q;
  logic signed [ACC_W-1:0]  sum_c;

  // Stage 1: products and aligned constant
  for (genvar k = 0; k < 3; k++) begin : g_mul
    always_ff @(posedge clk) begin
      if (rst) prod_q[k] <= '0;
      else     prod_q[k] <= $signed(coef[k]) * $signed({1'b0, pix[k]});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) off_q <= '0;
    else     off_q <= $signed({{EXT_W{offset[OFF_W-1]}}, offset, {ALIGN{1'b0}}});
  end

  // Stage 2: accumulate
  always_comb begin
    sum_c = off_q;
    for (int k = 0; k < 3; k++) sum_c = sum_c + ACC_W'(prod_q[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= sum_c;
  end
endmodule

// File: rtl/csc_round_clamp.sv
module csc_round_clamp #(
  parameter int PIX_W = 8,
  parameter int FRAC  = 10,
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] acc,
  input  logic                    bypass,
  input  logic [PIX_W-1:0]        raw,
  output logic [PIX_W-1:0]        result
);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] rnd_c;
  logic [PIX_W-1:0]        sat_c;

  always_comb begin
    rnd_c = (acc + HALF) >>> FRAC;
    if (rnd_c < 0)         sat_c = '0;
    else if (rnd_c > MAXV) sat_c = '1;
    else                   sat_c = rnd_c[PIX_W-1:0];
  end

  // Stage 3: registered output
  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= bypass ? raw : sat_c;
  end

  assert_clamp_low_R6: assert property (@(posedge clk) disable iff (rst)
    (!bypass && acc < 0) |=> result == '0);

  assert_clamp_high_R6: assert property (@(posedge clk) disable iff (rst)
    (!bypass && acc >= (MAXV <<< FRAC)) |=> result == '1);
endmodule

// File: rtl/yuv2rgb_csc.sv
module yuv2rgb_csc
  import csc_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int COEF_W    = 13,
  parameter int COEF_FRAC = 10,
  parameter int OFF_W     = 14,
  parameter int OFF_FRAC  = 4,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              frame_start,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_c0,
  input  logic [PIX_W-1:0]  in_c1,
  input  logic [PIX_W-1:0]  in_c2,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b
);
  localparam int ALIGN  = COEF_FRAC - OFF_FRAC;
  localparam int PROD_W = COEF_W + PIX_W + 1;
  localparam int ACC_W  = PROD_W + 2;

  logic [NUM_REGS-1:0][REG_W-1:0] eff_coef;
  logic                           eff_bypass;

  csc_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start),
    .eff_coef(eff_coef), .eff_bypass(eff_bypass)
  );

  logic [2:0][PIX_W-1:0] pix_in, pix_s1, pix_s2;
  logic                  byp_s1, byp_s2, vld_s1, vld_s2;
  assign pix_in = {in_c2, in_c1, in_c0};

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_s1 <= '0; pix_s2 <= '0;
      byp_s1 <= 1'b0; byp_s2 <= 1'b0;
      vld_s1 <= 1'b0; vld_s2 <= 1'b0; out_valid <= 1'b0;
    end else begin
      pix_s1 <= pix_in;     pix_s2 <= pix_s1;
      byp_s1 <= eff_bypass; byp_s2 <= byp_s1;
      vld_s1 <= in_valid;   vld_s2 <= vld_s1; out_valid <= vld_s2;
    end
  end

  logic [2:0][PIX_W-1:0] row_out;

  // Rows: 0 = G (bypass from c1), 1 = R (c0), 2 = B (c2)
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    localparam int BASE = r * TERMS;
    localparam int RAW  = (r == 0) ? 1 : ((r == 1) ? 0 : 2);
    logic [2:0][COEF_W-1:0]  w;
    logic signed [ACC_W-1:0] acc;

    assign w = {eff_coef[BASE+2][COEF_W-1:0], eff_coef[BASE+1][COEF_W-1:0],
                eff_coef[BASE][COEF_W-1:0]};

    csc_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .OFF_W(OFF_W),
              .ALIGN(ALIGN), .ACC_W(ACC_W)) u_mac (
      .clk(clk), .rst(rst), .pix(pix_in), .coef(w),
      .offset(eff_coef[BASE+3][OFF_W-1:0]), .acc(acc)
    );

    csc_round_clamp #(.PIX_W(PIX_W), .FRAC(COEF_FRAC), .ACC_W(ACC_W)) u_rc (
      .clk(clk), .rst(rst), .acc(acc), .bypass(byp_s2),
      .raw(pix_s2[RAW]), .result(row_out[r])
    );
  end

  assign out_g = row_out[0];
  assign out_r = row_out[1];
  assign out_b = row_out[2];

  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)              warm_q <= '0;
    else if (warm_q != 3) warm_q <= warm_q + 2'd1;
  end

  assert_valid_delay_R7: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd3) |-> out_valid == $past(in_valid, 3));

  assert_idle_after_reset_R11: assert property (@(posedge clk) disable iff (rst)
    (warm_q < 2'd3) |-> !out_valid);

  assert_bypass_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && eff_bypass) |-> ##3 (out_r == $past(in_c0, 3) &&
      out_g == $past(in_c1, 3) && out_b == $past(in_c2, 3)));
endmodule

// File: tb/yuv2rgb_csc_test.sv
module yuv2rgb_csc_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic       frame_start = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_c0 = '0, in_c1 = '0, in_c2 = '0;
  logic       out_valid;
  logic [7:0] out_r, out_g, out_b;

  always #2 clk = ~clk;

  yuv2rgb_csc uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
    .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2), .out_valid(out_valid),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] m_sh [12];
  logic [31:0] m_act [12];
  logic        m_byp_sh = 1'b0, m_byp_act = 1'b0;
  logic [23:0] exp_q [$];
  string       tag_q [$];
  int          cyc_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] conv(input logic [31:0] wy, wu, wv, k,
                                      input logic [7:0] y, u, v);
    int s;
    s = int'($signed(wy[12:0])) * int'(y) + int'($signed(wu[12:0])) * int'(u)
      + int'($signed(wv[12:0])) * int'(v) + int'($signed(k[13:0])) * 64;
    s = (s + 512) >>> 10;
    if (s < 0) return 8'd0;
    if (s > 255) return 8'd255;
    return s[7:0];
  endfunction

  task automatic step(input bit fs, input bit we, input logic [3:0] a,
                      input logic [31:0] d, input bit v,
                      input logic [7:0] p0, p1, p2, input string tag);
    logic [7:0] r, g, b;
    @(negedge clk);
    frame_start = fs; cfg_we = we; cfg_addr = a; cfg_wdata = d;
    in_valid = v; in_c0 = p0; in_c1 = p1; in_c2 = p2;
    if (fs) begin
      for (int i = 0; i < 12; i++) m_act[i] = m_sh[i];
      m_byp_act = m_byp_sh;
    end
    if (v) begin
      if (m_byp_act) begin
        r = p0; g = p1; b = p2;
      end else begin
        g = conv(m_act[0], m_act[1], m_act[2], m_act[3], p0, p1, p2);
        r = conv(m_act[4], m_act[5], m_act[6], m_act[7], p0, p1, p2);
        b = conv(m_act[8], m_act[9], m_act[10], m_act[11], p0, p1, p2);
      end
      exp_q.push_back({r, g, b});
      tag_q.push_back(tag);
      cyc_q.push_back(cyc);
    end
    if (we) begin
      if (a < 12) m_sh[a] = d;
      else if (a == 12) m_byp_sh = d[0];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic pix(input logic [7:0] p0, p1, p2, input string tag);
    step(0, 0, 0, 0, 1, p0, p1, p2, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(0, 1, a, d, 0, 0, 0, 0, "");
  endtask

  // Monitor: pop and compare
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7 unexpected out_valid: actual 1 expected 0");
      end else begin
        logic [23:0] e;
        string t;
        int c0;
        e = exp_q.pop_front(); t = tag_q.pop_front(); c0 = cyc_q.pop_front();
        checks++;
        if ({out_r, out_g, out_b} !== e) begin
          fails++;
          $display("FAIL %s rgb: actual %h expected %h", t, {out_r, out_g, out_b}, e);
        end
        checks++;
        if (cyc - c0 != 3) begin
          fails++;
          $display("FAIL R7 latency: actual %0d expected 3", cyc - c0);
        end
      end
    end
  end

  task automatic finish_run();
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R7 outputs missing: actual %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R7 watchdog: actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_sh[0] = 32'h4a7; m_sh[1] = 32'h1e6f; m_sh[2] = 32'h1cbf; m_sh[3] = 32'h877;
    m_sh[4] = 32'h4a7; m_sh[5] = 32'h0;    m_sh[6] = 32'h662;  m_sh[7] = 32'h3211;
    m_sh[8] = 32'h4a7; m_sh[9] = 32'h812;  m_sh[10] = 32'h0;   m_sh[11] = 32'h2eb1;
    for (int i = 0; i < 12; i++) m_act[i] = m_sh[i];

    // R11: idle during and after reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        fails++; $display("FAIL R11 out_valid in reset: actual %b expected 0", out_valid);
      end
    end
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        fails++; $display("FAIL R11 out_valid after reset: actual %b expected 0", out_valid);
      end
    end

    // R1, R4: default matrix, back-to-back and with gaps
    pix(8'd16, 8'd128, 8'd128, "R1");
    pix(8'd235, 8'd128, 8'd128, "R1");
    pix(8'd81, 8'd90, 8'd240, "R4");
    idle(1);
    pix(8'd145, 8'd54, 8'd34, "R4");
    idle(2);
    pix(8'd41, 8'd240, 8'd110, "R4");
    // R6: saturation on both ends
    pix(8'd255, 8'd255, 8'd255, "R6");
    pix(8'd0, 8'd0, 8'd0, "R6");
    pix(8'd255, 8'd0, 8'd255, "R6");
    idle(4);

    // R9: writes stay in shadow until frame_start
    wr(4'd0, 32'hFFFF_E200);           // R2: upper bits ignored, +0.5
    wr(4'd1, 32'h0); wr(4'd2, 32'h0); wr(4'd3, 32'h0);
    wr(4'd4, 32'h1E00);                // -0.5
    wr(4'd5, 32'h0); wr(4'd6, 32'h0);
    wr(4'd7, 32'hFFFF_C040);           // R3: +4.0, upper bits ignored
    wr(4'd8, 32'h0); wr(4'd9, 32'h0); wr(4'd10, 32'h0);
    wr(4'd11, 32'h00A8);               // R3: +10.5
    pix(8'd3, 8'd0, 8'd0, "R9");
    // R9: pixel in commit cycle uses new set
    step(1, 0, 0, 0, 1, 8'd3, 8'd0, 8'd0, "R9");
    // R5: exact halves round up; R2: sign
    pix(8'd1, 8'd0, 8'd0, "R5");
    pix(8'd2, 8'd0, 8'd0, "R5");
    pix(8'd5, 8'd9, 8'd7, "R2");
    pix(8'd20, 8'd0, 8'd0, "R6");
    idle(3);

    // R10: write in commit cycle is not committed by that pulse
    step(1, 1, 4'd11, 32'h3F00, 0, 0, 0, 0, "");   // -16.0 into shadow
    pix(8'd9, 8'd0, 8'd0, "R10");
    step(1, 0, 0, 0, 1, 8'd9, 8'd0, 8'd0, "R10");
    pix(8'd9, 8'd0, 8'd0, "R3");
    idle(3);

    // R8: bypass, commit together with a pixel, then leave bypass
    wr(4'd12, 32'h1);
    wr(4'd13, 32'hFFFF_FFFF);          // R4: unused address ignored
    pix(8'd10, 8'd20, 8'd30, "R8");
    step(1, 0, 0, 0, 1, 8'd200, 8'd17, 8'd99, "R8");
    pix(8'd0, 8'd255, 8'd128, "R8");
    wr(4'd12, 32'h0);
    pix(8'd1, 8'd2, 8'd3, "R8");
    step(1, 0, 0, 0, 1, 8'd4, 8'd0, 8'd0, "R8");
    idle(6);
    finish_run();
  end
endmodule